// File: doc/BRIEF.md
# Pipelined Bus Slot Tracker

This block is the central state keeper of a shared bus whose address phase runs apart from two separate data stages, one for reads and one for writes. Each direction has room for two outstanding masters: a primary master that owns the data stage of that direction and a secondary master that has finished its address phase and waits for that stage. One request arrives per cycle. The tracker decides at once whether the request is accepted or stalled, and it records which master fills which slot.

An init request opens an address phase. It needs a free address stage and a free slot in its direction. The address stage then stays busy for a fixed arbitration time and then waits for the slave to acknowledge the address. If no acknowledge comes before a cycle-counted timeout, the tracker reports a timeout for that master and frees the slot it held. A data-handshake request is taken only from the primary master of its direction. When that master sends its final beat, the secondary master moves up into the primary slot.

Top module: `bst_slot_tracker`

## Requirements
- R1: After synchronous reset all four slot outputs read 255 (empty), and `addr_busy`, `rd_busy`, `wr_busy` and `tmo_pulse` are 0.
- R2: An accepted init request (`req_kind`=0) fills the primary slot of its direction (`req_rnw`=1 read, 0 write) when that slot is empty, otherwise the secondary slot; `grant_sec` is 1 in the same cycle exactly when the secondary slot is used. A secondary slot is never occupied while the primary slot of its direction is empty.
- R3: An init request stalls when both slots of its direction are occupied, while an init request of the other direction can still be accepted.
- R4: An init request is accepted only while `addr_busy` is 0. Acceptance makes `addr_busy` 1 from the next cycle, for ARB_CYC arbitration cycles followed by the acknowledge wait.
- R5: `slv_ack` is honoured only during the acknowledge wait, which starts ARB_CYC+1 cycles after acceptance. An acknowledge there makes `addr_busy` 0 in the next cycle; an acknowledge during arbitration has no effect.
- R6: If no acknowledge arrives in the TMO_CYC wait cycles, `tmo_pulse` is 1 for exactly one cycle with `tmo_master` set to the master, in the same cycle `addr_busy` returns to 0 and the slot held by that master reads 255.
- R7: A data request (`req_kind`=1) is accepted only from the master held in the primary slot of its direction, and not while that master's own address phase is still pending.
- R8: An accepted data beat makes the busy flag of its direction 1 from the next cycle. The flag stays 1 until the cycle after a beat with `req_last`=1 and drops in the first cycle with no open burst and no beat in the previous cycle.
- R9: An accepted data beat with `req_last`=1 moves the secondary master of that direction into the primary slot and sets the secondary slot to 255 in the next cycle.
- R10: A request carrying master ID 255 is never accepted, and an init request is stalled when the same master already holds a slot of that direction.
- R11: `req_stall` is 1 exactly when `req_valid` is 1 and `req_accept` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 1 | 0 = init (address) request, 1 = data-handshake beat |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_master | input | 8 | ID of the requesting master (255 reserved) |
| req_last | input | 1 | Final beat of a data transfer |
| slv_ack | input | 1 | Slave acknowledges the pending address |
| req_accept | output | 1 | Request accepted this cycle |
| req_stall | output | 1 | Request presented but not accepted |
| grant_sec | output | 1 | Accepted init request went to a secondary slot |
| addr_busy | output | 1 | Address stage busy |
| rd_busy | output | 1 | Read data stage busy |
| wr_busy | output | 1 | Write data stage busy |
| slot_pri_rd | output | 8 | Primary read master (255 = empty) |
| slot_sec_rd | output | 8 | Secondary read master |
| slot_pri_wr | output | 8 | Primary write master |
| slot_sec_wr | output | 8 | Secondary write master |
| tmo_pulse | output | 1 | Address timeout reported |
| tmo_master | output | 8 | Master whose address phase timed out |

## Verification
Accept, stall and the secondary-grant flag are combinational on the request and current state, so the bench reads them in the same cycle, after the inputs have settled and before the next edge. Slot contents, data-stage busy flags and the promotion are due one edge after the accepted request. The address stage is due one edge after acceptance, reaches its wait phase ARB_CYC+1 edges after acceptance, and is idle again one edge after a honoured acknowledge or ARB_CYC+TMO_CYC+1 edges after acceptance on a timeout. The bench drives inputs one time unit after each rising edge, checks comb outputs one unit later, and checks registered results one unit after the edge where they are due.

// File: rtl/bst_pkg.sv
package bst_pkg;

    localparam int ID_W = 8;
    localparam logic [ID_W-1:0] NO_MASTER = '1;

    typedef logic [ID_W-1:0] mid_t;

    typedef enum logic {
        KIND_INIT = 1'b0,
        KIND_DATA = 1'b1
    } req_kind_e;

    typedef enum logic [1:0] {
        AS_IDLE = 2'd0,
        AS_ARB  = 2'd1,
        AS_WAIT = 2'd2
    } astage_e;

    typedef struct packed {
        mid_t pri_rd;
        mid_t sec_rd;
        mid_t pri_wr;
        mid_t sec_wr;
    } slots_t;

    typedef struct packed {
        logic      vld;
        logic      rnw;
        logic      sec;
        mid_t      id;
    } grant_t;

    function automatic logic slot_free(input mid_t s);
        return s == NO_MASTER;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bst_slot_file.sv
module bst_slot_file
    import bst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  grant_t grant,
    input  logic   promote_rd,
    input  logic   promote_wr,
    input  logic   drop_vld,
    input  logic   drop_rnw,
    input  mid_t   drop_id,
    output slots_t slots
);

    slots_t cur_q;
    slots_t after_grant;
    slots_t after_promote;
    slots_t nxt;

    // Stage 1: place a newly granted master.
    always_comb begin
        after_grant = cur_q;
        if (grant.vld) begin
            if (grant.rnw) begin
                if (grant.sec) after_grant.sec_rd = grant.id;
                else           after_grant.pri_rd = grant.id;
            end else begin
                if (grant.sec) after_grant.sec_wr = grant.id;
                else           after_grant.pri_wr = grant.id;
            end
        end
    end

    // Stage 2: move secondaries up when a primary finishes.
    always_comb begin
        after_promote = after_grant;
        if (promote_rd) begin
            after_promote.pri_rd = after_grant.sec_rd;
            after_promote.sec_rd = NO_MASTER;
        end
        if (promote_wr) begin
            after_promote.pri_wr = after_grant.sec_wr;
            after_promote.sec_wr = NO_MASTER;
        end
    end

    // Stage 3: release the slot of a master whose address phase expired.
    always_comb begin
        nxt = after_promote;
        if (drop_vld) begin
            if (drop_rnw) begin
                if (after_promote.sec_rd == drop_id) begin
                    nxt.sec_rd = NO_MASTER;
                end else if (after_promote.pri_rd == drop_id) begin
                    nxt.pri_rd = after_promote.sec_rd;
                    nxt.sec_rd = NO_MASTER;
                end
            end else begin
                if (after_promote.sec_wr == drop_id) begin
                    nxt.sec_wr = NO_MASTER;
                end else if (after_promote.pri_wr == drop_id) begin
                    nxt.pri_wr = after_promote.sec_wr;
                    nxt.sec_wr = NO_MASTER;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{pri_rd: NO_MASTER, sec_rd: NO_MASTER,
                       pri_wr: NO_MASTER, sec_wr: NO_MASTER};
        end else begin
            cur_q <= nxt;
        end
    end

    assign slots = cur_q;

endmodule

// File: rtl/bst_addr_stage.sv
module bst_addr_stage
    import bst_pkg::*;
#(
    parameter int unsigned ARB_CYC = 2,
    parameter int unsigned TMO_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  mid_t start_id,
    input  logic start_rnw,
    input  logic slv_ack,
    output logic busy,
    output mid_t pend_id,
    output logic pend_rnw,
    output logic expire,
    output logic tmo_pulse,
    output mid_t tmo_id
);

    localparam int unsigned MAX_CNT = max2(ARB_CYC, TMO_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] ARB_LOAD = CNT_W'(ARB_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TMO_CYC - 1);

    astage_e          st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    mid_t             id_q;
    logic             rnw_q;
    logic             tmo_q;
    mid_t             tmo_id_q;

    assign expire = (st_q == AS_WAIT) && (cnt_q == '0) && !slv_ack;

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        unique case (st_q)
            AS_IDLE: begin
                if (start) begin
                    st_nxt  = AS_ARB;
                    cnt_nxt = ARB_LOAD;
                end
            end
            AS_ARB: begin
                if (cnt_q == '0) begin
                    st_nxt  = AS_WAIT;
                    cnt_nxt = TMO_LOAD;
                end else begin
                    cnt_nxt = cnt_q - 1'b1;
                end
            end
            AS_WAIT: begin
                if (slv_ack || cnt_q == '0) begin
                    st_nxt  = AS_IDLE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q - 1'b1;
                end
            end
            default: begin
                st_nxt  = AS_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= AS_IDLE;
            cnt_q    <= '0;
            id_q     <= NO_MASTER;
            rnw_q    <= 1'b0;
            tmo_q    <= 1'b0;
            tmo_id_q <= NO_MASTER;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
            tmo_q <= expire;
            if (start && st_q == AS_IDLE) begin
                id_q  <= start_id;
                rnw_q <= start_rnw;
            end
            if (expire) begin
                tmo_id_q <= id_q;
            end
        end
    end

    assign busy      = (st_q != AS_IDLE);
    assign pend_id   = id_q;
    assign pend_rnw  = rnw_q;
    assign tmo_pulse = tmo_q;
    assign tmo_id    = tmo_id_q;

endmodule

// File: rtl/bst_data_stage.sv
module bst_data_stage (
    input  logic clk,
    input  logic rst,
    input  logic beat,
    input  logic last,
    output logic busy
);

    logic busy_q;
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            open_q <= 1'b0;
        end else if (beat) begin
            busy_q <= 1'b1;
            open_q <= !last;
        end else begin
            busy_q <= open_q;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/bst_slot_tracker.sv
module bst_slot_tracker
    import bst_pkg::*;
#(
    parameter int unsigned ARB_CYC = 2,
    parameter int unsigned TMO_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_kind,
    input  logic            req_rnw,
    input  logic [ID_W-1:0] req_master,
    input  logic            req_last,
    input  logic            slv_ack,
    output logic            req_accept,
    output logic            req_stall,
    output logic            grant_sec,
    output logic            addr_busy,
    output logic            rd_busy,
    output logic            wr_busy,
    output logic [ID_W-1:0] slot_pri_rd,
    output logic [ID_W-1:0] slot_sec_rd,
    output logic [ID_W-1:0] slot_pri_wr,
    output logic [ID_W-1:0] slot_sec_wr,
    output logic            tmo_pulse,
    output logic [ID_W-1:0] tmo_master
);

    slots_t    slots;
    grant_t    grant;
    req_kind_e kind;
    mid_t      dir_pri, dir_sec;
    mid_t      pend_id;
    logic      pend_rnw;
    logic      expire;
    logic      init_ok, data_ok, id_ok;
    logic      own_pending;
    logic      is_data_beat, is_init;
    logic [1:0] beat_dir;
    logic [1:0] stage_busy;

    assign kind    = req_kind_e'(req_kind);
    assign dir_pri = req_rnw ? slots.pri_rd : slots.pri_wr;
    assign dir_sec = req_rnw ? slots.sec_rd : slots.sec_wr;
    assign id_ok   = !slot_free(req_master);

    // Init: address stage idle, master not already holding this direction,
    // and at least one slot of the direction free.
    always_comb begin
        init_ok = !addr_busy && id_ok
                  && (dir_pri != req_master) && (dir_sec != req_master)
                  && (slot_free(dir_pri) || slot_free(dir_sec));
    end

    // Data: only the primary master, and not while its own address is pending.
    always_comb begin
        own_pending = addr_busy && (pend_id == req_master) && (pend_rnw == req_rnw);
        data_ok     = id_ok && (dir_pri == req_master) && !own_pending;
    end

    always_comb begin
        req_accept = 1'b0;
        if (req_valid) begin
            req_accept = (kind == KIND_DATA) ? data_ok : init_ok;
        end
    end

    assign req_stall    = req_valid && !req_accept;
    assign is_init      = req_accept && (kind == KIND_INIT);
    assign is_data_beat = req_accept && (kind == KIND_DATA);
    assign grant_sec    = is_init && !slot_free(dir_pri);

    always_comb begin
        grant.vld = is_init;
        grant.rnw = req_rnw;
        grant.sec = grant_sec;
        grant.id  = req_master;
    end

    bst_slot_file u_slots (
        .clk        (clk),
        .rst        (rst),
        .grant      (grant),
        .promote_rd (is_data_beat && req_rnw && req_last),
        .promote_wr (is_data_beat && !req_rnw && req_last),
        .drop_vld   (expire),
        .drop_rnw   (pend_rnw),
        .drop_id    (pend_id),
        .slots      (slots)
    );

    bst_addr_stage #(
        .ARB_CYC (ARB_CYC),
        .TMO_CYC (TMO_CYC)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .start     (is_init),
        .start_id  (req_master),
        .start_rnw (req_rnw),
        .slv_ack   (slv_ack),
        .busy      (addr_busy),
        .pend_id   (pend_id),
        .pend_rnw  (pend_rnw),
        .expire    (expire),
        .tmo_pulse (tmo_pulse),
        .tmo_id    (tmo_master)
    );

    // Index 0 = write stage, index 1 = read stage.
    assign beat_dir[0] = is_data_beat && !req_rnw;
    assign beat_dir[1] = is_data_beat && req_rnw;

    for (genvar d = 0; d < 2; d++) begin : g_dstage
        bst_data_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .beat (beat_dir[d]),
            .last (req_last),
            .busy (stage_busy[d])
        );
    end

    assign wr_busy     = stage_busy[0];
    assign rd_busy     = stage_busy[1];
    assign slot_pri_rd = slots.pri_rd;
    assign slot_sec_rd = slots.sec_rd;
    assign slot_pri_wr = slots.pri_wr;
    assign slot_sec_wr = slots.sec_wr;

endmodule

// File: rtl/bst_slot_tracker_chk.sv
module bst_slot_tracker_chk
    import bst_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_kind,
    input logic            req_rnw,
    input logic [ID_W-1:0] req_master,
    input logic            req_last,
    input logic            req_accept,
    input logic            req_stall,
    input logic            addr_busy,
    input logic            rd_busy,
    input logic            wr_busy,
    input logic [ID_W-1:0] slot_pri_rd,
    input logic [ID_W-1:0] slot_sec_rd,
    input logic [ID_W-1:0] slot_pri_wr,
    input logic [ID_W-1:0] slot_sec_wr,
    input logic            tmo_pulse
);

    AST_SEC_RD_NEEDS_PRI: assert property (@(posedge clk) disable iff (rst)
        (slot_sec_rd != NO_MASTER) |-> (slot_pri_rd != NO_MASTER)); // R2
    AST_SEC_WR_NEEDS_PRI: assert property (@(posedge clk) disable iff (rst)
        (slot_sec_wr != NO_MASTER) |-> (slot_pri_wr != NO_MASTER)); // R2
    AST_INIT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_accept && !req_kind) |-> !addr_busy); // R4
    AST_INIT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_accept && !req_kind) |=> addr_busy); // R4
    AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tmo_pulse |=> !tmo_pulse); // R6
    AST_TMO_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        tmo_pulse |-> !addr_busy); // R6
    AST_DATA_RD_FROM_PRI: assert property (@(posedge clk) disable iff (rst)
        (req_accept && req_kind && req_rnw) |-> (req_master == slot_pri_rd)); // R7
    AST_DATA_WR_FROM_PRI: assert property (@(posedge clk) disable iff (rst)
        (req_accept && req_kind && !req_rnw) |-> (req_master == slot_pri_wr)); // R7
    AST_RD_BEAT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_accept && req_kind && req_rnw) |=> rd_busy); // R8
    AST_WR_BEAT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_accept && req_kind && !req_rnw) |=> wr_busy); // R8
    AST_RD_PROMOTE: assert property (@(posedge clk) disable iff (rst)
        (req_accept && req_kind && req_rnw && req_last)
        |=> ((slot_pri_rd == $past(slot_sec_rd)) || tmo_pulse)); // R9
    AST_NO_RESERVED_ID: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> (req_master != NO_MASTER)); // R10
    AST_STALL_RULE: assert property (@(posedge clk) disable iff (rst)
        req_stall == (req_valid && !req_accept)); // R11

endmodule

bind bst_slot_tracker bst_slot_tracker_chk u_chk (.*);

// File: tb/sim_bst_slot_tracker.sv
module sim_bst_slot_tracker;

    localparam int ARB = 2;
    localparam int TMO = 4;
    localparam int NV  = 17;
    localparam logic [7:0] E = 8'd255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_kind = 1'b0, req_rnw = 1'b0, req_last = 1'b0, slv_ack = 1'b0;
    logic [7:0] req_master = 8'd0;
    logic req_accept, req_stall, grant_sec, addr_busy, rd_busy, wr_busy, tmo_pulse;
    logic [7:0] slot_pri_rd, slot_sec_rd, slot_pri_wr, slot_sec_wr, tmo_master;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bst_slot_tracker #(.ARB_CYC(ARB), .TMO_CYC(TMO)) u0 (.*);

    // Row: {valid, kind, rnw, id[7:0], last, ack, exp_accept, exp_sec}
    localparam logic [14:0] VEC [NV] = '{
        {1'b1,1'b0,1'b1,8'd1,  1'b0,1'b0,1'b1,1'b0}, // 0 init rd 1 -> primary (R2)
        {1'b1,1'b0,1'b0,8'd2,  1'b0,1'b0,1'b0,1'b0}, // 1 init while addr busy (R4)
        {1'b0,1'b0,1'b0,8'd0,  1'b0,1'b1,1'b0,1'b0}, // 2 ack in arbitration (R5)
        {1'b0,1'b0,1'b0,8'd0,  1'b0,1'b1,1'b0,1'b0}, // 3 ack in wait (R5)
        {1'b1,1'b1,1'b1,8'd1,  1'b0,1'b0,1'b1,1'b0}, // 4 data rd from primary (R7)
        {1'b1,1'b0,1'b1,8'd3,  1'b0,1'b0,1'b1,1'b1}, // 5 init rd 3 -> secondary (R2)
        {1'b1,1'b1,1'b1,8'd1,  1'b0,1'b0,1'b1,1'b0}, // 6 data rd 1 during other address (R7)
        {1'b1,1'b1,1'b1,8'd3,  1'b0,1'b0,1'b0,1'b0}, // 7 data from secondary (R7)
        {1'b0,1'b0,1'b0,8'd0,  1'b0,1'b1,1'b0,1'b0}, // 8 ack
        {1'b1,1'b0,1'b1,8'd4,  1'b0,1'b0,1'b0,1'b0}, // 9 both read slots full (R3)
        {1'b1,1'b0,1'b0,8'd4,  1'b0,1'b0,1'b1,1'b0}, // 10 write still accepted (R3)
        {1'b1,1'b1,1'b0,8'd4,  1'b0,1'b0,1'b0,1'b0}, // 11 own address pending (R7)
        {1'b1,1'b1,1'b1,8'd1,  1'b1,1'b0,1'b1,1'b0}, // 12 last rd beat (R9)
        {1'b1,1'b1,1'b1,8'd3,  1'b1,1'b1,1'b1,1'b0}, // 13 promoted master data + ack
        {1'b1,1'b0,1'b1,8'd255,1'b0,1'b0,1'b0,1'b0}, // 14 reserved ID (R10)
        {1'b1,1'b0,1'b0,8'd4,  1'b0,1'b0,1'b0,1'b0}, // 15 duplicate master (R10)
        {1'b1,1'b1,1'b0,8'd4,  1'b1,1'b0,1'b1,1'b0}  // 16 last wr beat
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic k, input logic r,
                         input logic [7:0] id, input logic l, input logic a);
        req_valid = v; req_kind = k; req_rnw = r; req_master = id; req_last = l; slv_ack = a;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check("R1 pri_rd", slot_pri_rd, E);
        check("R1 sec_rd", slot_sec_rd, E);
        check("R1 pri_wr", slot_pri_wr, E);
        check("R1 sec_wr", slot_sec_wr, E);
        check("R1 busy", {addr_busy, rd_busy, wr_busy, tmo_pulse}, 0);

        // Vector walk: one row per cycle
        for (int i = 0; i < NV; i++) begin
            logic [14:0] r;
            r = VEC[i];
            if (i == 6) check("R2 sec_rd holds 3", slot_sec_rd, 8'd3);
            if (i == 13) begin
                check("R9 promoted pri_rd", slot_pri_rd, 8'd3);
                check("R9 sec_rd emptied", slot_sec_rd, E);
            end
            if (i == 4) check("R5 addr idle after ack", addr_busy, 0);
            drive(r[14], r[13], r[12], r[11:4], r[3], r[2]);
            #1;
            check($sformatf("R7 accept row %0d", i), req_accept, r[1]);
            check($sformatf("R11 stall row %0d", i), req_stall, r[14] & ~r[1]);
            if (r[1] && !r[13]) check($sformatf("R2 grant_sec row %0d", i), grant_sec, r[0]);
            step();
        end
        drive(0, 0, 0, 8'd0, 0, 0);
        check("R9 all empty rd", {slot_pri_rd, slot_sec_rd}, {E, E});
        check("R9 all empty wr", {slot_pri_wr, slot_sec_wr}, {E, E});
        check("R4 addr idle", addr_busy, 0);

        // R6 timeout
        drive(1, 0, 0, 8'd7, 0, 0);
        #1;
        check("R6 init accept", req_accept, 1);
        step();
        drive(0, 0, 0, 8'd0, 0, 0);
        check("R4 busy after accept", addr_busy, 1);
        for (int k = 1; k < ARB + TMO; k++) step();
        check("R6 busy in last wait", addr_busy, 1);
        check("R6 no early pulse", tmo_pulse, 0);
        step();
        check("R6 tmo pulse", tmo_pulse, 1);
        check("R6 tmo master", tmo_master, 8'd7);
        check("R6 addr idle", addr_busy, 0);
        check("R6 slot freed", slot_pri_wr, E);
        step();
        check("R6 pulse one cycle", tmo_pulse, 0);

        // R8 data-stage busy
        drive(1, 0, 1, 8'd9, 0, 0);
        step();
        drive(0, 0, 0, 8'd0, 0, 0);
        for (int k = 1; k < ARB + 1; k++) step();
        drive(0, 0, 0, 8'd0, 0, 1);
        step();
        drive(1, 1, 1, 8'd9, 0, 0);
        #1;
        check("R7 primary data after ack", req_accept, 1);
        step();
        drive(0, 0, 0, 8'd0, 0, 0);
        check("R8 rd busy after beat", rd_busy, 1);
        check("R8 wr untouched", wr_busy, 0);
        step();
        check("R8 rd busy open burst", rd_busy, 1);
        drive(1, 1, 1, 8'd9, 1, 0);
        step();
        drive(0, 0, 0, 8'd0, 0, 0);
        check("R8 rd busy after last", rd_busy, 1);
        check("R9 slot emptied", slot_pri_rd, E);
        step();
        check("R8 rd idle", rd_busy, 0);

        // R1 reset clears a held slot
        drive(1, 0, 0, 8'd5, 0, 0);
        step();
        drive(0, 0, 0, 8'd0, 0, 0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 reset clears slot", slot_pri_wr, E);
        check("R1 reset clears addr", addr_busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule